// File: doc/BRIEF.md
# Activity-Triggered Auto Power-Down Controller

This controller decides, clock by clock, whether a memory array should sit at its full operating power level or drop to a low standby level. It watches both chip enables (one active-low, one active-high), the write strobe, the address bus and the write-data bus. A qualifying edge or transition on any of these, while the memory is selected, counts as activity. Activity lifts the block into the active state and loads a hold timer.

When the hold timer runs out with no further activity, the block falls back to standby. This happens even if the memory stays selected, so power depends on access rate rather than on how long select is held. Dropping select forces standby at once.

All inputs pass through a synchroniser of `SYNC_STAGES` flops. Each edge detector compares the synchronised value with its value one clock earlier. From an input change to a visible output change, the latency is therefore `SYNC_STAGES + 1` clock cycles.

Top module: `apd_ctrl`

## Requirements
- R1: After reset, and until the first qualifying event, `pwr_active` is 0 and `pwr_standby` is 1.
- R2: A 0-to-1 change of `en_hi` while `en_lo_n` is 0 is a wake event.
- R3: A 1-to-0 change of `en_lo_n` while `en_hi` is 1 is a wake event.
- R4: A 1-to-0 change of `wr_n` while both enables are active (`en_lo_n`=0, `en_hi`=1) is a wake event.
- R5: A change of any `addr` bit while both enables are active is a wake event. An address change while deselected has no effect on the outputs.
- R6: A change of any `wdata` bit is a wake event only while both enables are active and `wr_n` is 0. A data change with `wr_n` at 1 has no effect on the outputs.
- R7: A wake event makes `pwr_active` 1 exactly `SYNC_STAGES+1` cycles after the input change. It stays 1 for `HOLD_CYCLES` cycles and then returns to 0 when no further event occurs, even while the memory stays selected.
- R8: A wake event during the active period restarts the full `HOLD_CYCLES` window from that event.
- R9: The memory is deselected when `en_lo_n`=1 or `en_hi`=0. Deselection forces standby `SYNC_STAGES+1` cycles after the input change, whatever time is left on the hold window.
- R10: `pwr_active` and `pwr_standby` are always complementary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_lo_n | input | 1 | Active-low chip enable |
| en_hi | input | 1 | Active-high chip enable |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Memory address bus |
| wdata | input | DATA_W | Memory write-data bus |
| pwr_active | output | 1 | High while the array should be at full power |
| pwr_standby | output | 1 | High while the array may be in standby |

## Verification
The bench targets the qualifying gates. A data change with the write strobe idle, or an address change while deselected, must leave the block in standby; a design that ignores the gating would wake spuriously. It checks retriggering by issuing a second event late in the window: a design that does not reload would fall to standby early at the first window's end. It also holds select with no activity, which a level-based design would keep active forever. Finally, it deselects mid-window, where a design without the forced clear would stay active until the timer drained.

// File: rtl/apd_pkg.sv
package apd_pkg;

  typedef struct packed {
    logic en_lo_n;
    logic en_hi;
    logic wr_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{en_lo_n: 1'b1, en_hi: 1'b0, wr_n: 1'b1};

  function automatic int cnt_width(input int hold);
    return (hold < 1) ? 1 : $clog2(hold + 1);
  endfunction

  function automatic logic is_selected(input ctl_t c);
    return (!c.en_lo_n) && c.en_hi;
  endfunction

  function automatic logic is_writing(input ctl_t c);
    return is_selected(c) && !c.wr_n;
  endfunction

  function automatic logic fell(input logic now_v, input logic old_v);
    return old_v && !now_v;
  endfunction

  function automatic logic rose(input logic now_v, input logic old_v);
    return now_v && !old_v;
  endfunction

endpackage

// File: rtl/apd_sync.sv
module apd_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/apd_event_detect.sv
module apd_event_detect
  import apd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl_cur,
  input  logic [ADDR_W-1:0] addr_cur,
  input  logic [DATA_W-1:0] data_cur,
  output logic              ev_hi_rise,
  output logic              ev_lo_fall,
  output logic              ev_wr_fall,
  output logic              ev_addr,
  output logic              ev_data,
  output logic              sel_now,
  output logic              desel_now,
  output logic              wake
);

  ctl_t              ctl_prev;
  logic [ADDR_W-1:0] addr_prev;
  logic [DATA_W-1:0] data_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_prev  <= CTL_IDLE;
      addr_prev <= '0;
      data_prev <= '0;
    end else begin
      ctl_prev  <= ctl_cur;
      addr_prev <= addr_cur;
      data_prev <= data_cur;
    end
  end

  logic addr_moved, data_moved;

  always_comb begin
    sel_now    = is_selected(ctl_cur);
    desel_now  = !sel_now;
    addr_moved = |(addr_cur ^ addr_prev);
    data_moved = |(data_cur ^ data_prev);
    ev_hi_rise = rose(ctl_cur.en_hi, ctl_prev.en_hi) && !ctl_cur.en_lo_n;
    ev_lo_fall = fell(ctl_cur.en_lo_n, ctl_prev.en_lo_n) && ctl_cur.en_hi;
    ev_wr_fall = fell(ctl_cur.wr_n, ctl_prev.wr_n) && sel_now;
    ev_addr    = addr_moved && sel_now;
    ev_data    = data_moved && is_writing(ctl_cur);
    wake       = ev_hi_rise | ev_lo_fall | ev_wr_fall | ev_addr | ev_data;
  end

  // R6: a data-driven event implies the write strobe was low at the same time
  assert_data_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |-> (!ctl_cur.wr_n && sel_now));

  // R9: no wake can be reported while deselected
  assert_no_wake_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    desel_now |-> !wake);

endmodule

// File: rtl/apd_hold_timer.sv
module apd_hold_timer
  import apd_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  localparam int CW = cnt_width(HOLD_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake,
  input  logic          force_off,
  output logic [CW-1:0] remain,
  output logic          running
);

  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES);

  function automatic logic [CW-1:0] next_remain(
    input logic          off,
    input logic          ev,
    input logic [CW-1:0] cur
  );
    if (off)           return '0;
    else if (ev)       return RELOAD;
    else if (cur != 0) return cur - CW'(1);
    else               return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= '0;
    else        remain <= next_remain(force_off, wake, remain);
  end

  assign running = (remain != '0);

  // R9: deselection clears the window on the next edge
  assert_force_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (remain == '0));

  // R8: every event reloads the full window
  assert_reload_on_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !force_off) |=> (remain == RELOAD));

  // R7: without events the window counts down by one
  assert_decay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake && !force_off && remain != '0) |=> (remain == $past(remain) - CW'(1)));

  // R7: an idle timer stays idle
  assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake && remain == '0) |=> (remain == '0));

endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
  import apd_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_lo_n,
  input  logic              en_hi,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              pwr_active,
  output logic              pwr_standby
);

  localparam int CW    = cnt_width(HOLD_CYCLES);
  localparam int BUS_W = ADDR_W + DATA_W;

  ctl_t              ctl_raw, ctl_s;
  logic [BUS_W-1:0]  bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  assign ctl_raw = '{en_lo_n: en_lo_n, en_hi: en_hi, wr_n: wr_n};

  apd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d_in(ctl_raw), .q_out(ctl_s)
  );

  apd_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d_in({addr, wdata}), .q_out(bus_s)
  );

  assign addr_s = bus_s[BUS_W-1:DATA_W];
  assign data_s = bus_s[DATA_W-1:0];

  logic ev_hi_rise, ev_lo_fall, ev_wr_fall, ev_addr, ev_data;
  logic sel_now, desel_now, wake;

  apd_event_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_events (
    .clk(clk), .rst_n(rst_n),
    .ctl_cur(ctl_s), .addr_cur(addr_s), .data_cur(data_s),
    .ev_hi_rise(ev_hi_rise), .ev_lo_fall(ev_lo_fall), .ev_wr_fall(ev_wr_fall),
    .ev_addr(ev_addr), .ev_data(ev_data),
    .sel_now(sel_now), .desel_now(desel_now), .wake(wake)
  );

  logic [CW-1:0] remain;
  logic          running;

  apd_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .wake(wake), .force_off(desel_now),
    .remain(remain), .running(running)
  );

  assign pwr_active  = running;
  assign pwr_standby = !running;

  // R10: outputs never agree
  assert_outputs_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_active ^ pwr_standby);

  // R2: leaving standby always follows a detected event
  assert_rise_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_active) |-> $past(wake));

  // R9: active power never coexists with a deselect seen a cycle earlier
  assert_desel_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    desel_now |=> pwr_standby);

endmodule

// File: tb/apd_ctrl_tb.sv
module apd_ctrl_tb_top;

  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;
  localparam int HOLD   = 12;
  localparam int SYNC   = 2;
  localparam int SNAP_W = 3 + ADDR_W + DATA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_lo_n = 1'b1, en_hi = 1'b0, wr_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic pwr_active, pwr_standby;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  apd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_lo_n(en_lo_n), .en_hi(en_hi), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .pwr_active(pwr_active), .pwr_standby(pwr_standby)
  );

  // Behavioural reference: history of sampled inputs and an integer timer.
  logic [SNAP_W-1:0] hist[$];
  int model_left = 0;
  localparam logic [SNAP_W-1:0] IDLE_SNAP = {1'b1, 1'b0, 1'b1, {(ADDR_W+DATA_W){1'b0}}};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < SYNC + 2; i++) hist.push_back(IDLE_SNAP);
      model_left = 0;
    end else begin
      logic [SNAP_W-1:0] now_s, old_s;
      bit lo_now, hi_now, wr_now, lo_old, hi_old, wr_old, on, ev;
      hist.push_front({en_lo_n, en_hi, wr_n, addr, wdata});
      void'(hist.pop_back());
      now_s = hist[SYNC];
      old_s = hist[SYNC+1];
      lo_now = now_s[SNAP_W-1]; hi_now = now_s[SNAP_W-2]; wr_now = now_s[SNAP_W-3];
      lo_old = old_s[SNAP_W-1]; hi_old = old_s[SNAP_W-2]; wr_old = old_s[SNAP_W-3];
      on = !lo_now && hi_now;
      ev = 0;
      if (hi_now && !hi_old && !lo_now) ev = 1;
      if (!lo_now && lo_old && hi_now) ev = 1;
      if (on && !wr_now && wr_old) ev = 1;
      if (on && now_s[ADDR_W+DATA_W-1:DATA_W] != old_s[ADDR_W+DATA_W-1:DATA_W]) ev = 1;
      if (on && !wr_now && now_s[DATA_W-1:0] != old_s[DATA_W-1:0]) ev = 1;
      if (!on) model_left = 0;
      else if (ev) model_left = HOLD;
      else if (model_left > 0) model_left--;
    end
  end

  // Per-cycle comparison against the model (R7, R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pwr_active !== (model_left > 0) || pwr_standby !== !(model_left > 0)) begin
        fails++;
        $display("FAIL R10 model compare: active=%0b standby=%0b expected active=%0b",
                 pwr_active, pwr_standby, model_left > 0);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_active(input bit exp, input string req);
    checks++;
    if (pwr_active !== exp || pwr_standby !== !exp) begin
      fails++;
      $display("FAIL %s: active=%0b standby=%0b expected active=%0b",
               req, pwr_active, pwr_standby, exp);
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_active(0, "R1 reset state");
    tick(4);
    expect_active(0, "R1 idle after reset");

    // High enable rises while low enable inactive: no wake
    en_hi = 1'b1;
    tick(SYNC + 3);
    expect_active(0, "R2 no wake while deselected");

    // R3: low enable falls with high enable already active
    en_lo_n = 1'b0;
    tick(SYNC + 1);
    expect_active(1, "R3 wake on low-enable fall");
    tick(HOLD - 1);
    expect_active(1, "R7 window still open");
    tick(1);
    expect_active(0, "R7 standby while still selected");

    // R5 + R8: address change, then retrigger late in the window
    addr = 17'h00005;
    tick(SYNC + 1);
    expect_active(1, "R5 wake on address change");
    tick(4);
    addr = 17'h10005;
    tick(SYNC + 1);
    tick(HOLD - 1);
    expect_active(1, "R8 retrigger extends window");
    tick(1);
    expect_active(0, "R8 window ends after retrigger");

    // R6: data change with write strobe idle is ignored
    wdata = 8'hA5;
    tick(SYNC + 1);
    expect_active(0, "R6 data ignored without write");
    tick(3);
    expect_active(0, "R6 data ignored without write later");

    // R4: write strobe falls
    wr_n = 1'b0;
    tick(SYNC + 1);
    expect_active(1, "R4 wake on write fall");
    tick(HOLD);
    expect_active(0, "R7 standby during held write");

    // R6: data change while writing
    wdata = 8'h3C;
    tick(SYNC + 1);
    expect_active(1, "R6 wake on data during write");

    // R9: deselect mid-window
    tick(2);
    en_hi = 1'b0;
    wr_n = 1'b1;
    tick(SYNC + 1);
    expect_active(0, "R9 deselect forces standby");

    // R5: address change while deselected ignored
    addr = 17'h0ABCD;
    tick(SYNC + 1);
    expect_active(0, "R5 address ignored while deselected");

    // R2: high enable rises with low enable active
    en_hi = 1'b1;
    tick(SYNC + 1);
    expect_active(1, "R2 wake on high-enable rise");
    en_lo_n = 1'b1;
    tick(SYNC + 1);
    expect_active(0, "R9 low enable released");
    tick(5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R7 watchdog expired: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule